// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-attached watchdog. A programmable prescaler divides the core clock down to a slow tick, typically one millisecond, and a 16-bit elapsed counter advances once per tick while the watchdog runs. Software programs a timeout in ticks. While the watchdog runs, software keeps it alive by writing to a restart address, which clears the elapsed count. If the count reaches the timeout and expiry reset is enabled, the block raises a system reset output for a fixed number of clock cycles.

The elapsed count and the timeout share one register. Software can therefore read both in one access and subtract them to find the time left. The tick path has two enables, one for the clock and one for the divider, and tick generation needs both of them. Resetting the system on expiry is a separate control bit.

Top module: `wdog_timer`

## Requirements
- R1: After reset every register reads as zero, the elapsed count is zero and `reset_out` is low.
- R2: Byte address 0x0 is the control register, 0x8 is the timeout/count register and 0xC is the restart register. Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`. Control bits that are not defined read back as zero. The restart address reads as zero.
- R3: With control bit 24 (clock enable) and bit 25 (divider enable) both set, a tick occurs every D cycles, where D is control bits 17:0. A divisor of zero acts as one. The elapsed count rises by one per tick while control bit 18 (run) is set and the count is below the timeout.
- R4: The elapsed count holds when run is clear, when the clock enable is clear, or when the divider enable is clear.
- R5: Any write to the control register, and any cycle with the divider enable clear, restarts the prescaler from zero. The first tick after a control write therefore comes a full D cycles later.
- R6: A write to address 0xC clears the elapsed count to zero, whatever the data. This write takes priority over a tick in the same cycle.
- R7: Bits 15:0 of the timeout/count register hold the timeout. Bits 31:16 return the elapsed count, and writes to those bits are ignored.
- R8: The elapsed count never exceeds the timeout. Without an expiry reset it stays at the timeout. Writing a timeout below the current count pulls the count down to the new timeout.
- R9: With run and control bit 21 (expiry reset enable) set, `reset_out` goes high in the cycle after the count reaches the timeout. It stays high for exactly 16 cycles, and the count is cleared as the pulse ends.
- R10: `reset_out` never rises while the expiry reset enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reset_out | output | 1 | System reset request on expiry |

## Verification
The hardest case to set up from the ports is showing that a control write restarts the prescaler. That needs the prescaler sitting at a known non-zero phase at the moment of the write. The stimulus gets there by letting the divider run freely with run clear for an exact number of cycles, then doing one restart write and rewriting the control register. It then reads the count on either side of the first full period. The expiry pulse is located to the exact cycle by sampling `reset_out` every cycle after the enabling write. The bench then reads the count again to confirm it was cleared at the end of the pulse and that counting resumed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WORD_W     = 32;
    localparam int DIV_W      = 18;
    localparam int BIT_RUN    = 18;
    localparam int BIT_RST_EN = 21;
    localparam int BIT_CLK_EN = 24;
    localparam int BIT_DIV_EN = 25;
    localparam int CNT_SHIFT  = 16;

    localparam logic [3:0] OFF_CTRL    = 4'h0;
    localparam logic [3:0] OFF_TCNT    = 4'h8;
    localparam logic [3:0] OFF_RESTART = 4'hC;

    typedef struct packed {
        logic             div_en;
        logic             clk_en;
        logic             rst_en;
        logic             run;
        logic [DIV_W-1:0] divisor;
    } ctrl_t;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_PULSE = 1'b1
    } pulse_state_e;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.divisor = w[DIV_W-1:0];
        c.run     = w[BIT_RUN];
        c.rst_en  = w[BIT_RST_EN];
        c.clk_en  = w[BIT_CLK_EN];
        c.div_en  = w[BIT_DIV_EN];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w             = '0;
        w[DIV_W-1:0]  = c.divisor;
        w[BIT_RUN]    = c.run;
        w[BIT_RST_EN] = c.rst_en;
        w[BIT_CLK_EN] = c.clk_en;
        w[BIT_DIV_EN] = c.div_en;
        return w;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             clear,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last;

    // zero divisor behaves as divide-by-one
    assign last = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick = active && (phase_q >= last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (active) begin
            phase_q <= (phase_q >= last) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             limit_wr,
    input  logic [CNT_W-1:0] limit_wdata,
    input  logic             zero_req,
    output logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] elapsed,
    output logic             at_limit
);
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q   <= '0;
            elapsed_q <= '0;
        end else begin
            if (limit_wr) begin
                limit_q <= limit_wdata;
            end
            if (zero_req) begin
                elapsed_q <= '0;
            end else if (limit_wr) begin
                if (elapsed_q > limit_wdata) begin
                    elapsed_q <= limit_wdata;
                end
            end else if (tick && run && (elapsed_q < limit_q)) begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end

    assign limit    = limit_q;
    assign elapsed  = elapsed_q;
    assign at_limit = (elapsed_q == limit_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse,
    output logic done
);
    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

    pulse_state_e state_q;
    logic [PW-1:0] len_q;

    assign pulse = (state_q == PS_PULSE);
    assign done  = pulse && (len_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            len_q   <= '0;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    len_q <= '0;
                    if (fire) begin
                        state_q <= PS_PULSE;
                    end
                end
                PS_PULSE: begin
                    if (len_q == LAST) begin
                        state_q <= PS_IDLE;
                        len_q   <= '0;
                    end else begin
                        len_q <= len_q + 1'b1;
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              reset_out
);
    ctrl_t             ctrl_q;
    logic              sel_ctrl, sel_tcnt, sel_restart;
    logic              ctrl_wr, tcnt_wr, restart_wr;
    logic              tick, tick_active, presc_clear;
    logic [CNT_W-1:0]  limit, elapsed;
    logic              at_limit, fire, pulse_done, zero_req;
    logic [WORD_W-1:0] tcnt_word;
    logic [WORD_W-1:0] rdata_q;

    assign sel_ctrl    = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_tcnt    = (bus_addr == ADDR_W'(OFF_TCNT));
    assign sel_restart = (bus_addr == ADDR_W'(OFF_RESTART));
    assign ctrl_wr     = bus_wr && sel_ctrl;
    assign tcnt_wr     = bus_wr && sel_tcnt;
    assign restart_wr  = bus_wr && sel_restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_from_word(bus_wdata);
        end
    end

    assign tick_active = ctrl_q.clk_en && ctrl_q.div_en;
    assign presc_clear = ctrl_wr || !ctrl_q.div_en;

    wdog_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .active  (tick_active),
        .clear   (presc_clear),
        .divisor (ctrl_q.divisor),
        .tick    (tick)
    );

    assign zero_req = restart_wr || pulse_done;

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .run         (ctrl_q.run),
        .limit_wr    (tcnt_wr),
        .limit_wdata (bus_wdata[CNT_W-1:0]),
        .zero_req    (zero_req),
        .limit       (limit),
        .elapsed     (elapsed),
        .at_limit    (at_limit)
    );

    assign fire = ctrl_q.run && ctrl_q.rst_en && at_limit;

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (reset_out),
        .done  (pulse_done)
    );

    always_comb begin
        tcnt_word                        = '0;
        tcnt_word[CNT_W-1:0]             = limit;
        tcnt_word[CNT_SHIFT +: CNT_W]    = elapsed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            if (sel_ctrl) begin
                rdata_q <= ctrl_to_word(ctrl_q);
            end else if (sel_tcnt) begin
                rdata_q <= tcnt_word;
            end else begin
                rdata_q <= '0;
            end
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             restart_wr,
    input logic             run,
    input logic             rst_en,
    input logic             clk_en,
    input logic             div_en,
    input logic [CNT_W-1:0] elapsed,
    input logic [CNT_W-1:0] limit,
    input logic             reset_out
);
    localparam int HW = $clog2(PULSE_LEN + 1);
    logic [HW-1:0] high_run;

    always_ff @(posedge clk) begin
        if (rst || !reset_out) begin
            high_run <= '0;
        end else begin
            high_run <= high_run + 1'b1;
        end
    end

    AST_COUNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        elapsed <= limit);                                                    // R8

    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
        restart_wr |=> (elapsed == '0));                                      // R6

    AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
        ((!run || !clk_en || !div_en) && !bus_wr && !reset_out) |=> $stable(elapsed)); // R4

    AST_PULSE_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (rst)
        reset_out |-> (high_run < HW'(PULSE_LEN)));                           // R9

    AST_PULSE_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_out) |-> (high_run == HW'(PULSE_LEN)));                   // R9

    AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_out) |-> $past(run && rst_en));                           // R10
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .restart_wr (restart_wr),
    .run        (ctrl_q.run),
    .rst_en     (ctrl_q.rst_en),
    .clk_en     (ctrl_q.clk_en),
    .div_en     (ctrl_q.div_en),
    .elapsed    (elapsed),
    .limit      (limit),
    .reset_out  (reset_out)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        reset_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] RUN  = 32'h0004_0000;
    localparam logic [31:0] RSTE = 32'h0020_0000;
    localparam logic [31:0] CLKE = 32'h0100_0000;
    localparam logic [31:0] DIVE = 32'h0200_0000;

    always #2.5 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reset_out (reset_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each read against the scoreboard entry
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #500000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int first_high;
        int high_cnt;
        bit saw_reset;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(4'h0, 32'h0, "R1 ctrl after reset");
        bus_read(4'h8, 32'h0, "R1 tcnt after reset");
        check({31'b0, reset_out}, 32'h0, "R1 reset_out low");

        // R7 upper bits of timeout register are read-only
        bus_write(4'h8, 32'hABCD_0064);
        bus_read(4'h8, 32'h0000_0064, "R7 upper write ignored");

        // R3 counting with divisor 4; R2 control readback drops stray bits
        bus_write(4'h0, RUN | CLKE | DIVE | 32'd4 | 32'hC0D8_0000);
        idle(10);
        bus_read(4'h8, 32'h0002_0064, "R3 two ticks after ten cycles");
        bus_read(4'h0, RUN | CLKE | DIVE | 32'd4, "R2 ctrl readback");

        // R6 restart with arbitrary data; R2 restart reads zero
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'h8, 32'h0000_0064, "R6 restart clears count");
        bus_read(4'hC, 32'h0, "R2 restart address reads zero");

        // R4 run clear
        bus_write(4'h0, CLKE | DIVE | 32'd4);
        bus_write(4'hC, 32'h0);
        idle(20);
        bus_read(4'h8, 32'h0000_0064, "R4 hold with run clear");

        // R4 clock enable clear
        bus_write(4'h0, RUN | DIVE | 32'd4);
        idle(20);
        bus_read(4'h8, 32'h0000_0064, "R4 hold with clock enable clear");

        // R5 prescaler restarted by control write
        bus_write(4'h0, CLKE | DIVE | 32'd4);
        idle(7);
        bus_write(4'hC, 32'h0);
        bus_write(4'h0, RUN | CLKE | DIVE | 32'd4);
        idle(3);
        bus_read(4'h8, 32'h0000_0064, "R5 no tick before full period");
        bus_read(4'h8, 32'h0001_0064, "R5 tick at full period");

        // R3 divisor zero, R8 saturation, R10 no pulse without enable
        bus_write(4'h0, CLKE | DIVE);
        bus_write(4'hC, 32'h0);
        bus_write(4'h8, 32'h0000_0003);
        bus_write(4'h0, RUN | CLKE | DIVE);
        idle(2);
        bus_read(4'h8, 32'h0002_0003, "R3 divisor zero ticks every cycle");
        saw_reset = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (reset_out) saw_reset = 1'b1;
        end
        check({31'b0, saw_reset}, 32'h0, "R10 no pulse with expiry reset off");
        bus_read(4'h8, 32'h0003_0003, "R8 count saturates at timeout");

        // R8 smaller timeout clamps count
        bus_write(4'h8, 32'h0000_0002);
        bus_read(4'h8, 32'h0002_0002, "R8 clamp to new timeout");

        // R9 expiry pulse
        bus_write(4'h0, CLKE | DIVE);
        bus_write(4'hC, 32'h0);
        bus_write(4'h8, 32'h0000_0005);
        bus_write(4'h0, RUN | RSTE | CLKE | DIVE | 32'd2);
        first_high = -1;
        high_cnt = 0;
        for (int j = 1; j <= 30; j++) begin
            @(negedge clk);
            if (reset_out) begin
                if (first_high < 0) first_high = j;
                high_cnt++;
            end
        end
        check(32'(first_high), 32'd11, "R9 pulse start cycle");
        check(32'(high_cnt), 32'd16, "R9 pulse width");
        bus_read(4'h8, 32'h0002_0005, "R9 count cleared at pulse end");
        bus_write(4'h0, CLKE | DIVE);
        idle(20);
        check({31'b0, reset_out}, 32'h0, "R9 no pulse after stop");

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule